// File: doc/BRIEF.md
# Framed Parallel Word Link (Transmitter and Receiver)

This block carries addressed command packets across a narrow board-to-module parallel link. The link has a clock line, one sync line and a 16-bit data bus, and it moves one word per clock. The transmitter takes a request made of an address word and a command word. It then pulls the payload words one per cycle from a local source and places them on the bus as a framed packet. Each packet is the address word, then the command word, then zero to 255 payload words. The low byte of the command word gives the payload count.

The receiver watches the sync and data lines and recovers each packet. It presents the address and command together with a one-cycle header strobe, then each payload word with a valid strobe, and it marks the final payload word. A sync pulse that arrives before the current packet is complete aborts that packet. The receiver reports the abort with a one-cycle framing error and decodes the new packet that the sync pulse started. The top module holds one transmitter and one receiver. Their link sides are brought out separately, so the two can be joined in loopback or wired to a remote peer.

Top module: `pkt_link`

## Requirements
- R1: When the transmitter is idle and accepts no request, on the next cycle the link data lines are all zero and sync is low.
- R2: Sync is high for exactly one cycle per packet, and during that cycle the data lines carry the request's address word.
- R3: The command word appears on the data lines in the cycle right after the address word.
- R4: The payload length is bits [7:0] of the command word. A value of 0 sends a header-only packet; the maximum is 255 words.
- R5: `busy` rises in the cycle after a request is accepted (`req_valid` high while `busy` is low). It falls in the cycle in which the last word of the packet is on the link. Requests made while `busy` is high are ignored.
- R6: After the command word is captured, the receiver pulses `hdr_valid` for one cycle with `hdr_addr` and `hdr_cmd` equal to the sent address and command.
- R7: Each payload word is presented once, in order, with `data_valid`. `data_last` is high together with `data_valid` on the final word only.
- R8: A sync pulse while a packet's header or payload is still incomplete pulses `frame_error` for one cycle. The aborted packet yields no further words and no `data_last`, and the new packet is decoded normally.
- R9: A sync pulse while the receiver is idle starts a packet with no error. Words with sync low outside a packet produce no strobe.
- R10: The transmitter asserts `pay_take` once per payload word, exactly as many cycles as the payload length. It sends `pay_word` as it stands in each such cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request to send a packet |
| req_addr | input | 16 | Address word of the request |
| req_cmd | input | 16 | Command word; bits [7:0] are the payload length |
| busy | output | 1 | Transmitter is sending a packet |
| pay_take | output | 1 | Transmitter consumes `pay_word` this cycle |
| pay_word | input | 16 | Next payload word from the local source |
| link_sync_o | output | 1 | Transmitted sync line |
| link_data_o | output | 16 | Transmitted data lines |
| link_sync_i | input | 1 | Received sync line |
| link_data_i | input | 16 | Received data lines |
| hdr_valid | output | 1 | Received header strobe |
| hdr_addr | output | 16 | Received address word |
| hdr_cmd | output | 16 | Received command word |
| data_valid | output | 1 | Received payload word strobe |
| data_word | output | 16 | Received payload word |
| data_last | output | 1 | Final payload word of the packet |
| frame_error | output | 1 | Packet aborted by an early sync |

## Verification
The bench targets the length extremes 0, 1, 2 and 255. An off-by-one in the length counter would drop or add a word, or misplace `data_last`. A header-only packet that wrongly entered the payload phase would swallow the next packet's address. Early sync is injected during both the payload and the command phase. A receiver that missed either case would complete the stale packet or pulse no error. Requests made while busy, and noise words with sync low between packets, are also tested. A design that obeyed them would emit extra headers or stray data strobes.

// File: rtl/pkt_link_pkg.sv
package pkt_link_pkg;
   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_ADDR = 2'd1,
      TX_CMD  = 2'd2,
      TX_PAY  = 2'd3
   } tx_state_e;

   typedef enum logic [1:0] {
      RX_IDLE = 2'd0,
      RX_CMD  = 2'd1,
      RX_PAY  = 2'd2
   } rx_state_e;
endpackage

// File: rtl/pkt_link_tx.sv
module pkt_link_tx
   import pkt_link_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int LEN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [WORD_W-1:0] req_addr,
   input  logic [WORD_W-1:0] req_cmd,
   output logic              busy,
   output logic              pay_take,
   input  logic [WORD_W-1:0] pay_word,
   output logic              link_sync,
   output logic [WORD_W-1:0] link_data
);
   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

   tx_state_e         st;
   logic [WORD_W-1:0] addr_q;
   logic [WORD_W-1:0] cmd_q;
   logic [LEN_W-1:0]  left_q;
   logic              accept;

   assign accept   = req_valid && (st == TX_IDLE);
   assign busy     = (st != TX_IDLE);
   assign pay_take = (st == TX_PAY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= TX_IDLE;
         addr_q    <= '0;
         cmd_q     <= '0;
         left_q    <= '0;
         link_sync <= 1'b0;
         link_data <= '0;
      end else begin
         unique case (st)
            TX_IDLE: begin
               link_sync <= 1'b0;
               link_data <= '0;
               if (accept) begin
                  addr_q <= req_addr;
                  cmd_q  <= req_cmd;
                  st     <= TX_ADDR;
               end
            end
            TX_ADDR: begin
               link_sync <= 1'b1;
               link_data <= addr_q;
               left_q    <= cmd_q[LEN_W-1:0];
               st        <= TX_CMD;
            end
            TX_CMD: begin
               link_sync <= 1'b0;
               link_data <= cmd_q;
               st        <= (left_q == '0) ? TX_IDLE : TX_PAY;
            end
            TX_PAY: begin
               link_sync <= 1'b0;
               link_data <= pay_word;
               left_q    <= left_q - LEN_ONE;
               if (left_q == LEN_ONE) st <= TX_IDLE;
            end
            default: st <= TX_IDLE;
         endcase
      end
   end

   // R1: an idle, non-accepting transmitter leaves the bus quiet
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !req_valid) |=> (!link_sync && link_data == '0));

   // R2: sync never lasts more than one word
   p_sync_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      link_sync |=> !link_sync);

   // R3: command word follows the sync word
   p_cmd_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      link_sync |=> (link_data == cmd_q));

   // R5: acceptance raises busy
   p_accept_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   // R10: payload is only pulled inside a packet
   p_take_in_pkt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pay_take |-> (busy && !link_sync));
endmodule

// File: rtl/pkt_link_rx.sv
module pkt_link_rx
   import pkt_link_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int LEN_W  = 8,
   parameter bit IN_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_sync,
   input  logic [WORD_W-1:0] link_data,
   output logic              hdr_valid,
   output logic [WORD_W-1:0] hdr_addr,
   output logic [WORD_W-1:0] hdr_cmd,
   output logic              data_valid,
   output logic [WORD_W-1:0] data_word,
   output logic              data_last,
   output logic              frame_error
);
   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

   logic              s_sync;
   logic [WORD_W-1:0] s_data;

   generate
      if (IN_REG) begin : g_in_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               s_sync <= 1'b0;
               s_data <= '0;
            end else begin
               s_sync <= link_sync;
               s_data <= link_data;
            end
         end
      end else begin : g_in_direct
         assign s_sync = link_sync;
         assign s_data = link_data;
      end
   endgenerate

   rx_state_e         st;
   logic [WORD_W-1:0] addr_hold;
   logic [LEN_W-1:0]  left_q;
   logic [LEN_W-1:0]  len_in;

   assign len_in = s_data[LEN_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= RX_IDLE;
         addr_hold   <= '0;
         left_q      <= '0;
         hdr_valid   <= 1'b0;
         hdr_addr    <= '0;
         hdr_cmd     <= '0;
         data_valid  <= 1'b0;
         data_word   <= '0;
         data_last   <= 1'b0;
         frame_error <= 1'b0;
      end else begin
         hdr_valid   <= 1'b0;
         data_valid  <= 1'b0;
         data_last   <= 1'b0;
         frame_error <= 1'b0;
         if (s_sync) begin
            frame_error <= (st != RX_IDLE);
            addr_hold   <= s_data;
            st          <= RX_CMD;
         end else begin
            unique case (st)
               RX_IDLE: ;
               RX_CMD: begin
                  hdr_valid <= 1'b1;
                  hdr_addr  <= addr_hold;
                  hdr_cmd   <= s_data;
                  left_q    <= len_in;
                  st        <= (len_in == '0) ? RX_IDLE : RX_PAY;
               end
               RX_PAY: begin
                  data_valid <= 1'b1;
                  data_word  <= s_data;
                  data_last  <= (left_q == LEN_ONE);
                  left_q     <= left_q - LEN_ONE;
                  if (left_q == LEN_ONE) st <= RX_IDLE;
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

   // R7: last marker only rides on a valid word
   p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      data_last |-> data_valid);

   // R6: header and payload strobes never coincide
   p_hdr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |-> !data_valid);

   // R8: an abort cycle emits no word and no last
   p_err_no_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_error |-> (!data_valid && !data_last && !hdr_valid));

   // R9: an idle receiver without sync stays silent
   p_idle_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_IDLE && !s_sync) |=> (!hdr_valid && !data_valid && !frame_error));
endmodule

// File: rtl/pkt_link.sv
module pkt_link #(
   parameter int WORD_W    = 16,
   parameter int LEN_W     = 8,
   parameter bit RX_IN_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [WORD_W-1:0] req_addr,
   input  logic [WORD_W-1:0] req_cmd,
   output logic              busy,
   output logic              pay_take,
   input  logic [WORD_W-1:0] pay_word,
   output logic              link_sync_o,
   output logic [WORD_W-1:0] link_data_o,
   input  logic              link_sync_i,
   input  logic [WORD_W-1:0] link_data_i,
   output logic              hdr_valid,
   output logic [WORD_W-1:0] hdr_addr,
   output logic [WORD_W-1:0] hdr_cmd,
   output logic              data_valid,
   output logic [WORD_W-1:0] data_word,
   output logic              data_last,
   output logic              frame_error
);
   generate
      if (LEN_W < 1 || LEN_W > WORD_W) begin : g_bad_len
         $error("pkt_link: LEN_W must lie in 1..WORD_W");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("pkt_link: WORD_W too small");
      end
   endgenerate

   pkt_link_tx #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_cmd   (req_cmd),
      .busy      (busy),
      .pay_take  (pay_take),
      .pay_word  (pay_word),
      .link_sync (link_sync_o),
      .link_data (link_data_o)
   );

   pkt_link_rx #(.WORD_W(WORD_W), .LEN_W(LEN_W), .IN_REG(RX_IN_REG)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .link_sync   (link_sync_i),
      .link_data   (link_data_i),
      .hdr_valid   (hdr_valid),
      .hdr_addr    (hdr_addr),
      .hdr_cmd     (hdr_cmd),
      .data_valid  (data_valid),
      .data_word   (data_word),
      .data_last   (data_last),
      .frame_error (frame_error)
   );
endmodule

// File: tb/tb_pkt_link.sv
module tb_pkt_link;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_cmd = '0;
   logic        busy, pay_take;
   logic [15:0] pay_word;
   logic        link_sync_o;
   logic [15:0] link_data_o;
   logic        inj_en = 1'b0;
   logic        inj_sync = 1'b0;
   logic [15:0] inj_data = '0;
   logic        rx_sync;
   logic [15:0] rx_data;
   logic        hdr_valid, data_valid, data_last, frame_error;
   logic [15:0] hdr_addr, hdr_cmd, data_word;

   integer n_checks = 0;
   integer n_fail = 0;

   always #2.5 clk = ~clk;

   assign rx_sync = inj_en ? inj_sync : link_sync_o;
   assign rx_data = inj_en ? inj_data : link_data_o;

   pkt_link dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_cmd(req_cmd),
      .busy(busy), .pay_take(pay_take), .pay_word(pay_word),
      .link_sync_o(link_sync_o), .link_data_o(link_data_o),
      .link_sync_i(rx_sync), .link_data_i(rx_data),
      .hdr_valid(hdr_valid), .hdr_addr(hdr_addr), .hdr_cmd(hdr_cmd),
      .data_valid(data_valid), .data_word(data_word),
      .data_last(data_last), .frame_error(frame_error)
   );

   // payload source
   integer      pidx = 0;
   integer      pbase = 0;
   logic [15:0] seed = '0;

   function automatic logic [15:0] pat(input logic [15:0] s, input integer k);
      logic [31:0] t;
      t = 32'(s) * 32'h9E37 + 32'(k) * 32'h0101;
      return t[15:0] ^ 16'h5A5A;
   endfunction

   assign pay_word = pat(seed, pidx - pbase);
   always @(posedge clk) if (pay_take) pidx <= pidx + 1;

   // monitor, sampled away from the active edge
   integer      n_hdr = 0, n_dv = 0, n_last = 0, n_err = 0, n_sync = 0;
   integer      last_pos = -1;
   logic [15:0] sync_word = '0;
   logic [15:0] got_w [0:4095];

   always @(negedge clk) begin
      if (rst_n) begin
         if (hdr_valid) n_hdr = n_hdr + 1;
         if (frame_error) n_err = n_err + 1;
         if (link_sync_o) begin
            n_sync = n_sync + 1;
            sync_word = link_data_o;
         end
         if (data_valid) begin
            got_w[n_dv % 4096] = data_word;
            if (data_last) begin
               n_last = n_last + 1;
               last_pos = n_dv;
            end
            n_dv = n_dv + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks = n_checks + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(busy == 1'b0, "R5", "busy after reset", busy, 0);
      chk(link_sync_o == 1'b0 && link_data_o == 16'h0, "R1", "bus after reset",
          link_data_o, 0);
      chk(!hdr_valid && !data_valid && !frame_error, "R9", "rx strobes after reset",
          {hdr_valid, data_valid, frame_error}, 0);
   endtask

   // send one packet through the loopback and check everything about it
   task automatic send_pkt(input logic [15:0] addr, input integer len,
                           input logic [7:0] hi, input bit poke_busy);
      integer b_hdr, b_dv, b_last, b_err, b_sync, b_take, guard, ok;
      logic [15:0] cmd;
      cmd = {hi, 8'(len)};
      @(negedge clk);
      seed = addr ^ {hi, hi};
      pbase = pidx;
      b_hdr = n_hdr; b_dv = n_dv; b_last = n_last; b_err = n_err; b_sync = n_sync;
      b_take = pidx;
      req_valid = 1'b1; req_addr = addr; req_cmd = cmd;
      @(negedge clk);
      chk(busy == 1'b1, "R5", "busy after accept", busy, 1);
      if (poke_busy) begin
         req_addr = addr ^ 16'hFFFF; req_cmd = 16'h0003;
         repeat (2) @(negedge clk);
      end
      req_valid = 1'b0;
      guard = 0;
      while (busy && guard < 1000) begin
         @(negedge clk);
         guard = guard + 1;
      end
      chk(guard < 1000, "R5", "busy falls", guard, 0);
      repeat (4) @(negedge clk);
      chk(!busy, "R5", "no second packet from ignored request", busy, 0);
      chk(link_sync_o == 1'b0 && link_data_o == 16'h0, "R1", "bus idle after packet",
          link_data_o, 0);
      chk(n_sync - b_sync == 1, "R2", "sync cycles per packet", n_sync - b_sync, 1);
      chk(sync_word == addr, "R2", "word under sync", sync_word, addr);
      chk(n_hdr - b_hdr == 1, "R6", "header strobes", n_hdr - b_hdr, 1);
      chk(hdr_addr == addr, "R6", "header address", hdr_addr, addr);
      chk(hdr_cmd == cmd, "R3", "command word", hdr_cmd, cmd);
      chk(pidx - b_take == len, "R10", "payload pulls", pidx - b_take, len);
      chk(n_dv - b_dv == len, "R4", "payload count", n_dv - b_dv, len);
      chk(n_err == b_err, "R8", "no error on clean packet", n_err - b_err, 0);
      ok = 1;
      for (int k = 0; k < len; k++)
         if (got_w[(b_dv + k) % 4096] != pat(seed, k)) ok = 0;
      chk(ok == 1, "R7", "payload order and content", ok, 1);
      if (len > 0) begin
         chk(n_last - b_last == 1 && last_pos == b_dv + len - 1, "R7",
             "last marker position", last_pos, b_dv + len - 1);
      end else begin
         chk(n_last == b_last, "R4", "header-only has no last", n_last - b_last, 0);
      end
   endtask

   task automatic inj(input logic s, input logic [15:0] d);
      inj_sync = s; inj_data = d;
      @(negedge clk);
   endtask

   task automatic t_abort_payload;
      integer b_hdr, b_dv, b_last, b_err;
      @(negedge clk);
      b_hdr = n_hdr; b_dv = n_dv; b_last = n_last; b_err = n_err;
      inj_en = 1'b1;
      inj(1'b1, 16'h1111);
      inj(1'b0, 16'h0005);
      inj(1'b0, 16'hAAAA);
      inj(1'b0, 16'hBBBB);
      inj(1'b1, 16'h2222);
      inj(1'b0, 16'h0001);
      inj(1'b0, 16'h7777);
      inj(1'b0, 16'h0000);
      repeat (3) @(negedge clk);
      inj_en = 1'b0;
      chk(n_err - b_err == 1, "R8", "one error pulse on payload abort", n_err - b_err, 1);
      chk(n_hdr - b_hdr == 2, "R8", "both headers seen", n_hdr - b_hdr, 2);
      chk(hdr_addr == 16'h2222, "R8", "new packet address", hdr_addr, 16'h2222);
      chk(n_dv - b_dv == 3, "R8", "partial words then new word", n_dv - b_dv, 3);
      chk(n_last - b_last == 1 && got_w[last_pos % 4096] == 16'h7777, "R8",
          "last only on new packet", got_w[last_pos % 4096], 16'h7777);
   endtask

   task automatic t_abort_header;
      integer b_hdr, b_dv, b_err;
      @(negedge clk);
      b_hdr = n_hdr; b_dv = n_dv; b_err = n_err;
      inj_en = 1'b1;
      inj(1'b1, 16'h3333);
      inj(1'b1, 16'h4444);
      inj(1'b0, 16'h9900);
      inj(1'b0, 16'h0000);
      repeat (3) @(negedge clk);
      inj_en = 1'b0;
      chk(n_err - b_err == 1, "R8", "error on header abort", n_err - b_err, 1);
      chk(n_hdr - b_hdr == 1 && hdr_addr == 16'h4444, "R8", "second header kept",
          hdr_addr, 16'h4444);
      chk(n_dv == b_dv, "R4", "header-only after abort has no data", n_dv - b_dv, 0);
   endtask

   task automatic t_idle_noise;
      integer b_hdr, b_dv, b_err;
      @(negedge clk);
      b_hdr = n_hdr; b_dv = n_dv; b_err = n_err;
      inj_en = 1'b1;
      for (int k = 0; k < 5; k++) inj(1'b0, 16'hC0DE + 16'(k));
      inj(1'b1, 16'h5555);
      inj(1'b0, 16'h0000);
      inj(1'b0, 16'h0000);
      repeat (2) @(negedge clk);
      inj_en = 1'b0;
      chk(n_dv == b_dv, "R9", "noise yields no data", n_dv - b_dv, 0);
      chk(n_err == b_err, "R9", "idle sync without error", n_err - b_err, 0);
      chk(n_hdr - b_hdr == 1 && hdr_addr == 16'h5555, "R9", "idle sync starts packet",
          hdr_addr, 16'h5555);
   endtask

   task automatic finish_run;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      n_checks = n_checks + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual=expired expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      send_pkt(16'h1234, 0,   8'hA0, 1'b0);
      send_pkt(16'h0F0F, 1,   8'h11, 1'b0);
      send_pkt(16'hBEEF, 2,   8'h22, 1'b0);
      send_pkt(16'h8001, 255, 8'h7E, 1'b0);
      send_pkt(16'h4242, 6,   8'h33, 1'b1);
      for (int i = 0; i < 8; i++)
         send_pkt(16'(i * 16'h1357 + 16'h0101), (i * 37 + 11) % 256, 8'(i * 29), 1'b0);
      t_abort_payload();
      t_abort_header();
      t_idle_noise();
      send_pkt(16'hCAFE, 3, 8'h5C, 1'b0);
      finish_run();
   end
endmodule